// File: doc/BRIEF.md
# Rotated Filter Bank Generator

This block holds one set of orientation-aware 3x3 convolution weights and turns them, on demand, into every rotated copy a convolution engine needs, so that no rotated copy is ever stored. Each stored input channel is one wide word that packs its four orientation kernels side by side. A single access therefore returns all four at once.

A sweep is launched with a one-cycle start pulse. Three counters (rotation, input channel, orientation slot) then walk every combination. For each combination the block first picks, from the stored word, the orientation kernel that a cyclic shift by the rotation index brings into the requested slot. It then turns that kernel's nine taps by the same number of quarter turns. Both steps are fixed index permutations chosen by multiplexers. One kernel is emitted per beat on a valid/ready interface, and a registered output stage keeps the rate at one kernel per clock while the consumer accepts. The weights are written through a plain channel-wide write port. Fetching them from external memory lies outside this block.

Top module: `rfb_gen`

## Requirements
- R1: After reset, out_valid, out_last and busy are low.
- R2: A start pulse while idle produces exactly 4*NCH*4 output beats. The innermost index is out_orient (0..3), then out_chan (0..NCH-1), and the outermost is out_rot (0..3), each counting upward from zero.
- R3: A beat with rotation r and orientation slot o carries the stored kernel of orientation (o - r) mod 4 of that channel, so the orientation shift is applied before the spatial turn.
- R4: Taps are numbered k = 3*row + col, with tap k in out_taps bits [k*W +: W] and tap 0 at the top left. Rotation r applies r clockwise quarter turns, and one turn makes output (row,col) equal to input (2-col,row).
- R5: A beat with out_rot = 0 carries the stored kernel of that slot unchanged.
- R6: While out_valid is high and out_ready is low, out_valid, out_taps, out_rot, out_chan, out_orient and out_last hold their values.
- R7: With out_ready held high, the beats of a sweep arrive on consecutive cycles with no gap.
- R8: out_last is high only on the final beat of a sweep. busy is low in the cycle after that beat is accepted.
- R9: A start pulse while busy is high is ignored. The running sweep keeps its order and count, and no second sweep follows it.
- R10: A write with wr_en high stores all four orientation kernels of channel wr_chan in one cycle. Kernel o sits in wr_data bits [o*9*W +: 9*W], and the new weights appear in the next sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write one stored channel |
| wr_chan | input | CW | Channel index to write |
| wr_data | input | 36*W | Four orientation kernels of nine taps each |
| start | input | 1 | Launch a sweep when idle |
| busy | output | 1 | Sweep running or final beat not yet taken |
| out_valid | output | 1 | Output beat available |
| out_ready | input | 1 | Consumer accepts the beat |
| out_taps | output | 9*W | Nine signed taps of the rotated kernel |
| out_rot | output | 2 | Rotation index of the beat |
| out_chan | output | CW | Input channel of the beat |
| out_orient | output | 2 | Orientation slot of the beat |
| out_last | output | 1 | Final beat of the sweep |

## Verification
The weights are filled with a pattern in which every tap of every orientation within a channel is distinct, and some values are negative. A wrong orientation pick or a wrong tap permutation therefore shows as a value mismatch rather than passing by coincidence. Every rotation is tried against every orientation slot. A lookup table of expected source orientations separates a left shift from a right shift, and rotation 0 separates identity from any permutation. A second sweep runs with a stalling consumer, a start pulse in mid-sweep and one rewritten channel. This separates a held output from a drifting one, and an ignored start from a restarted sweep. It also shows whether newly written weights are actually picked up.

// File: rtl/rfb_pkg.sv
package rfb_pkg;

  localparam int TAPS   = 9;
  localparam int ORIENT = 4;

  // source orientation for output slot o under rotation r (cyclic shift)
  function automatic logic [1:0] orient_src(input logic [1:0] o, input logic [1:0] r);
    return o - r;
  endfunction

  // source tap index for output tap k after r clockwise quarter turns
  function automatic int spin_src(input int k, input int r);
    int row, col, tmp;
    row = k / 3;
    col = k % 3;
    for (int i = 0; i < r; i++) begin
      tmp = row;
      row = 2 - col;
      col = tmp;
    end
    return 3 * row + col;
  endfunction

endpackage

// File: rtl/rfb_store.sv
module rfb_store #(
  parameter int W   = 8,
  parameter int NCH = 8,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int GW = rfb_pkg::ORIENT * rfb_pkg::TAPS * W
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_chan,
  input  logic [GW-1:0] wr_data,
  input  logic [CW-1:0] rd_chan,
  output logic [GW-1:0] rd_group
);

  logic [GW-1:0] mem [NCH];

  always_ff @(posedge clk) begin
    if (wr_en && (int'(wr_chan) < NCH)) mem[wr_chan] <= wr_data;
  end

  assign rd_group = mem[rd_chan];

endmodule

// File: rtl/rfb_seq.sv
module rfb_seq #(
  parameter int NCH = 8,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          adv,
  output logic          run,
  output logic [1:0]    rot,
  output logic [CW-1:0] chan,
  output logic [1:0]    orient,
  output logic          at_end
);

  localparam logic [CW-1:0] CH_MAX = CW'(NCH - 1);

  logic chan_wrap;

  assign chan_wrap = (chan == CH_MAX);
  assign at_end    = (rot == 2'd3) && chan_wrap && (orient == 2'd3);

  always_ff @(posedge clk) begin
    if (rst) begin
      run    <= 1'b0;
      rot    <= '0;
      chan   <= '0;
      orient <= '0;
    end else if (go) begin
      run    <= 1'b1;
      rot    <= '0;
      chan   <= '0;
      orient <= '0;
    end else if (adv) begin
      if (at_end) begin
        run    <= 1'b0;
        rot    <= '0;
        chan   <= '0;
        orient <= '0;
      end else begin
        orient <= orient + 2'd1;
        if (orient == 2'd3) begin
          if (chan_wrap) begin
            chan <= '0;
            rot  <= rot + 2'd1;
          end else begin
            chan <= chan + CW'(1);
          end
        end
      end
    end
  end

endmodule

// File: rtl/rfb_orient.sv
module rfb_orient #(
  parameter int W = 8,
  localparam int KW = rfb_pkg::TAPS * W,
  localparam int GW = rfb_pkg::ORIENT * KW
) (
  input  logic [GW-1:0] group,
  input  logic [1:0]    rot,
  input  logic [1:0]    orient,
  output logic [KW-1:0] kernel
);

  logic [1:0] src;

  assign src = rfb_pkg::orient_src(orient, rot);

  always_comb begin
    kernel = group[0 +: KW];
    for (int i = 1; i < rfb_pkg::ORIENT; i++) begin
      if (src == 2'(i)) kernel = group[i*KW +: KW];
    end
  end

endmodule

// File: rtl/rfb_spin.sv
module rfb_spin #(
  parameter int W = 8,
  localparam int KW = rfb_pkg::TAPS * W
) (
  input  logic [KW-1:0] kin,
  input  logic [1:0]    rot,
  output logic [KW-1:0] kout
);

  for (genvar k = 0; k < rfb_pkg::TAPS; k++) begin : g_tap
    localparam int S0 = rfb_pkg::spin_src(k, 0);
    localparam int S1 = rfb_pkg::spin_src(k, 1);
    localparam int S2 = rfb_pkg::spin_src(k, 2);
    localparam int S3 = rfb_pkg::spin_src(k, 3);
    logic [W-1:0] tap;
    always_comb begin
      case (rot)
        2'd0:    tap = kin[S0*W +: W];
        2'd1:    tap = kin[S1*W +: W];
        2'd2:    tap = kin[S2*W +: W];
        default: tap = kin[S3*W +: W];
      endcase
    end
    assign kout[k*W +: W] = tap;
  end

endmodule

// File: rtl/rfb_gen.sv
module rfb_gen #(
  parameter int W   = 8,
  parameter int NCH = 8,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int KW = rfb_pkg::TAPS * W,
  localparam int GW = rfb_pkg::ORIENT * KW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_chan,
  input  logic [GW-1:0] wr_data,
  input  logic          start,
  output logic          busy,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [KW-1:0] out_taps,
  output logic [1:0]    out_rot,
  output logic [CW-1:0] out_chan,
  output logic [1:0]    out_orient,
  output logic          out_last
);

  logic          seq_run;
  logic          seq_end;
  logic          go;
  logic          adv;
  logic          slot_free;
  logic [1:0]    cur_rot;
  logic [CW-1:0] cur_chan;
  logic [1:0]    cur_orient;
  logic [GW-1:0] rd_group;
  logic [KW-1:0] sel_kernel;
  logic [KW-1:0] spun_kernel;

  assign busy      = seq_run | out_valid;
  assign go        = start & ~busy;
  assign slot_free = ~out_valid | out_ready;
  assign adv       = seq_run & slot_free;

  rfb_store #(.W(W), .NCH(NCH)) u_store (
    .clk      (clk),
    .wr_en    (wr_en),
    .wr_chan  (wr_chan),
    .wr_data  (wr_data),
    .rd_chan  (cur_chan),
    .rd_group (rd_group)
  );

  rfb_seq #(.NCH(NCH)) u_seq (
    .clk    (clk),
    .rst    (rst),
    .go     (go),
    .adv    (adv),
    .run    (seq_run),
    .rot    (cur_rot),
    .chan   (cur_chan),
    .orient (cur_orient),
    .at_end (seq_end)
  );

  rfb_orient #(.W(W)) u_orient (
    .group  (rd_group),
    .rot    (cur_rot),
    .orient (cur_orient),
    .kernel (sel_kernel)
  );

  rfb_spin #(.W(W)) u_spin (
    .kin  (sel_kernel),
    .rot  (cur_rot),
    .kout (spun_kernel)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_last   <= 1'b0;
      out_taps   <= '0;
      out_rot    <= '0;
      out_chan   <= '0;
      out_orient <= '0;
    end else if (slot_free) begin
      out_valid <= adv;
      out_last  <= adv & seq_end;
      if (adv) begin
        out_taps   <= spun_kernel;
        out_rot    <= cur_rot;
        out_chan   <= cur_chan;
        out_orient <= cur_orient;
      end
    end
  end

endmodule

// File: rtl/rfb_gen_chk.sv
module rfb_gen_chk #(
  parameter int W   = 8,
  parameter int NCH = 8,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int KW = 9 * W
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          busy,
  input logic          out_valid,
  input logic          out_ready,
  input logic [KW-1:0] out_taps,
  input logic [1:0]    out_rot,
  input logic [CW-1:0] out_chan,
  input logic [1:0]    out_orient,
  input logic          out_last,
  input logic          adv,
  input logic [1:0]    cur_rot,
  input logic [CW-1:0] cur_chan,
  input logic [1:0]    cur_orient,
  input logic [KW-1:0] sel_kernel
);

  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> (!out_valid && !out_last && !busy));

  // R5
  identity_rot_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && cur_rot == 2'd0) |=> (out_taps == $past(sel_kernel)));

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_taps) && $stable(out_rot) &&
      $stable(out_chan) && $stable(out_orient) && $stable(out_last)));

  // R7
  no_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !out_last) |=> out_valid);

  // R8
  last_valid_chk: assert property (@(posedge clk) disable iff (rst) out_last |-> out_valid);

  // R8
  idle_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_last) |=> !busy);

  // R9
  start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (start && busy && !adv) |=> ($stable(cur_rot) && $stable(cur_chan) && $stable(cur_orient)));

endmodule

bind rfb_gen rfb_gen_chk #(.W(W), .NCH(NCH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .busy       (busy),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_taps   (out_taps),
  .out_rot    (out_rot),
  .out_chan   (out_chan),
  .out_orient (out_orient),
  .out_last   (out_last),
  .adv        (adv),
  .cur_rot    (cur_rot),
  .cur_chan   (cur_chan),
  .cur_orient (cur_orient),
  .sel_kernel (sel_kernel)
);

// File: tb/rfb_gen_tb.sv
module rfb_gen_tb;

  localparam int W     = 8;
  localparam int NCH   = 8;
  localparam int CW    = 3;
  localparam int KW    = 9 * W;
  localparam int GW    = 4 * KW;
  localparam int TOTAL = 4 * NCH * 4;

  // {rotation, output slot, expected source orientation}
  localparam logic [5:0] ORIENT_TBL [16] = '{
    {2'd0, 2'd0, 2'd0}, {2'd0, 2'd1, 2'd1}, {2'd0, 2'd2, 2'd2}, {2'd0, 2'd3, 2'd3},
    {2'd1, 2'd0, 2'd3}, {2'd1, 2'd1, 2'd0}, {2'd1, 2'd2, 2'd1}, {2'd1, 2'd3, 2'd2},
    {2'd2, 2'd0, 2'd2}, {2'd2, 2'd1, 2'd3}, {2'd2, 2'd2, 2'd0}, {2'd2, 2'd3, 2'd1},
    {2'd3, 2'd0, 2'd1}, {2'd3, 2'd1, 2'd2}, {2'd3, 2'd2, 2'd3}, {2'd3, 2'd3, 2'd0}
  };

  logic          clk;
  logic          rst;
  logic          wr_en;
  logic [CW-1:0] wr_chan;
  logic [GW-1:0] wr_data;
  logic          start;
  logic          busy;
  logic          out_valid;
  logic          out_ready;
  logic [KW-1:0] out_taps;
  logic [1:0]    out_rot;
  logic [CW-1:0] out_chan;
  logic [1:0]    out_orient;
  logic          out_last;

  int checks;
  int failures;
  int gen_of [NCH];
  logic [KW-1:0] cap [4][NCH][4];
  bit finished;

  rfb_gen #(.W(W), .NCH(NCH)) u_dut (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_chan    (wr_chan),
    .wr_data    (wr_data),
    .start      (start),
    .busy       (busy),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_taps   (out_taps),
    .out_rot    (out_rot),
    .out_chan   (out_chan),
    .out_orient (out_orient),
    .out_last   (out_last)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [7:0] kval(input int m, input int o, input int k, input int g);
    return 8'((m * 37 + o * 11 + k * 3 + 5 + g * 101) % 256);
  endfunction

  function automatic logic [KW-1:0] kern(input int m, input int o, input int g);
    logic [KW-1:0] v;
    for (int k = 0; k < 9; k++) v[k*W +: W] = kval(m, o, k, g);
    return v;
  endfunction

  // expected kernel: source picked by explicit coordinate cases per turn count
  function automatic logic [KW-1:0] turned(input logic [KW-1:0] kin, input int r);
    logic [KW-1:0] v;
    int row, col, sr, sc;
    for (int k = 0; k < 9; k++) begin
      row = k / 3;
      col = k % 3;
      case (r)
        0: begin sr = row;     sc = col;     end
        1: begin sr = 2 - col; sc = row;     end
        2: begin sr = 2 - row; sc = 2 - col; end
        default: begin sr = col; sc = 2 - row; end
      endcase
      v[k*W +: W] = kin[(3*sr + sc)*W +: W];
    end
    return v;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [KW-1:0] act, input logic [KW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load(input int m, input int g);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_chan = CW'(m);
    for (int o = 0; o < 4; o++) wr_data[o*KW +: KW] = kern(m, o, g);
    gen_of[m] = g;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic sweep(input int mode);
    int beats, cyc, gaps, er, em, eo, src;
    bit seen, stalled;
    logic [KW-1:0] hold_taps, expk;
    logic [6:0] hold_idx;
    logic [6:0] now_idx;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    beats = 0; cyc = 0; gaps = 0; seen = 0; stalled = 0;
    hold_taps = '0; hold_idx = '0;
    while (beats < TOTAL && cyc < 3000) begin
      @(negedge clk);
      cyc++;
      now_idx = {out_rot, out_chan, out_orient};
      if (stalled) begin
        // R6
        check(out_valid && out_taps == hold_taps && now_idx == hold_idx,
              "R6 stall hold", out_taps, hold_taps);
      end
      start     = (mode == 1 && cyc == 25);
      out_ready = (mode == 0) ? 1'b1 : (cyc % 3 != 0);
      if (mode == 0 && seen && !out_valid) gaps++;
      if (out_valid) seen = 1;
      if (out_valid && out_ready) begin
        eo  = beats % 4;
        em  = (beats / 4) % NCH;
        er  = beats / (4 * NCH);
        // R2
        check(out_rot == 2'(er) && out_chan == CW'(em) && out_orient == 2'(eo),
              "R2 order", KW'(now_idx), KW'({2'(er), CW'(em), 2'(eo)}));
        src  = (eo + 4 - er) % 4;
        expk = turned(kern(em, src, gen_of[em]), er);
        cap[er][em][eo] = out_taps;
        if (er == 0) check(out_taps == kern(em, eo, gen_of[em]), "R5 identity", out_taps, kern(em, eo, gen_of[em]));
        else         check(out_taps == expk, "R3 R4 rotated kernel", out_taps, expk);
        // R8
        check(out_last == (beats == TOTAL - 1), "R8 last flag", KW'(out_last), KW'(beats == TOTAL - 1));
        beats++;
      end
      stalled   = out_valid && !out_ready;
      hold_taps = out_taps;
      hold_idx  = now_idx;
    end
    start     = 1'b0;
    out_ready = 1'b1;
    check(beats == TOTAL, "R2 beat count", KW'(beats), KW'(TOTAL));
    if (mode == 0) check(gaps == 0, "R7 no gaps", KW'(gaps), KW'(0));
    @(negedge clk);
    check(!busy && !out_valid, "R8 idle after last", KW'({busy, out_valid}), KW'(0));
    repeat (6) @(negedge clk);
    // R9: mid-sweep start must not launch a second sweep
    check(!out_valid && !busy, "R9 no extra sweep", KW'({busy, out_valid}), KW'(0));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    checks = 0; failures = 0; finished = 0;
    rst = 1'b1; wr_en = 1'b0; wr_chan = '0; wr_data = '0;
    start = 1'b0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    // R1
    check(!out_valid && !out_last && !busy, "R1 reset state", KW'({out_valid, out_last, busy}), KW'(0));
    rst = 1'b0;
    @(negedge clk);
    check(!out_valid && !busy, "R1 idle after reset", KW'({out_valid, busy}), KW'(0));

    // R10: fill every channel with one write each
    for (int m = 0; m < NCH; m++) load(m, 0);

    sweep(0);

    // R3: walk the orientation table against captured beats
    for (int i = 0; i < 16; i++) begin
      int r, o, s;
      r = int'(ORIENT_TBL[i][5:4]);
      o = int'(ORIENT_TBL[i][3:2]);
      s = int'(ORIENT_TBL[i][1:0]);
      check(cap[r][0][o] == turned(kern(0, s, 0), r), "R3 table chan0", cap[r][0][o], turned(kern(0, s, 0), r));
      check(cap[r][NCH-1][o] == turned(kern(NCH-1, s, 0), r), "R3 table chan last",
            cap[r][NCH-1][o], turned(kern(NCH-1, s, 0), r));
    end

    // R4: single tap corner, rotation 1 tap 0 takes stored tap 6 (bottom-left)
    check(cap[1][2][1][0 +: W] == kval(2, 0, 6, 0), "R4 corner tap", KW'(cap[1][2][1][0 +: W]), KW'(kval(2, 0, 6, 0)));
    // R4: centre tap never moves
    check(cap[2][5][2][4*W +: W] == kval(5, 0, 4, 0), "R4 centre tap", KW'(cap[2][5][2][4*W +: W]), KW'(kval(5, 0, 4, 0)));

    // R10: rewrite channel 3, then stalling sweep with a mid-sweep start (R6, R9)
    load(3, 1);
    sweep(1);
    check(cap[0][3][2] == kern(3, 2, 1), "R10 new weights", cap[0][3][2], kern(3, 2, 1));

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule